// File: doc/BRIEF.md
# External Bus Cycle Timing Controller

This block turns single internal read and write requests into the strobe sequence of an asynchronous external memory bus. A requester presents a request with a direction, a byte-lane mask, a 24-bit address and 32-bit write data. The controller replies with a one-cycle completion pulse, and a read returns its data word. On the bus side it drives an address strobe, a chip select, a read strobe, one write strobe per lane, the address, the write data and a data output enable. All bus strobes are active low.

A configuration word sets the timing for each access: a wait count, a strobe delay, late chip-select assertion and chip-select hold. The block samples the word together with the request. A request accepted in the completion cycle, or in a chip-select hold cycle, begins the next access with no idle cycle, and chip select stays low across the join.

Top module: `ext_bus_cycle_ctrl`

## Requirements
- R1: While reset is held and right after it, every bus strobe is high (inactive), the output enable is low, the completion pulse is low and the request-ready output is high.
- R2: With the configuration word at zero, an access lasts two cycles. The address strobe is low in the first cycle, the read or write strobe is low in the second, and the completion pulse comes in the second.
- R3: The address strobe is low for exactly one cycle, the first cycle of each access. The address bus holds the requested address in every cycle of the access.
- R4: Configuration bit 5 (late select) set to 0 drives chip select low in the same cycle as the address strobe. Set to 1, it drives chip select low from the second cycle of an access that follows an idle cycle. Chip select stays low through the last cycle of every access.
- R5: When a new access is accepted in the completion cycle or in a hold cycle, chip select stays low through that access's first cycle, whatever the late-select bit says.
- R6: Configuration bit 6 (hold) set to 0 raises chip select in the cycle after the completion cycle. Set to 1, chip select stays low one more cycle and rises the cycle after that.
- R7: The wait field, configuration bits 3:0 with value W, keeps the read or write strobe low for 1+W cycles. The access then lasts 2+W cycles.
- R8: Configuration bit 4 (strobe delay) set to 1 puts one cycle with no strobe between the address-strobe cycle and the first strobe cycle. The access grows by one cycle.
- R9: For a read, the controller captures the bus input at the clock edge that closes the completion cycle. It presents that word on the read-data output from the next cycle until the next read completes.
- R10: For a write, write strobe i is low during the strobe cycles only when lane-mask bit i is 1. Bit 0 covers data bits 15:0 and bit 1 covers bits 31:16. The output enable is high and the write data is on the bus in every strobe cycle. The output enable stays high for one cycle after the strobes rise and is low in the cycle after that. The read strobe and the write strobes are never low together.
- R11: The completion pulse is high only in the last cycle of an access. Request-ready is high in idle, completion and hold cycles and low otherwise. An accepted request starts its address-strobe cycle on the next cycle.
- R12: The controller latches the configuration word, address, data and direction when it accepts a request. Changing these inputs during the access has no effect on the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_lanes | input | 2 | Byte-lane mask, one bit per write strobe |
| req_addr | input | 24 | Start-byte address |
| req_wdata | input | 32 | Write data |
| cfg_word | input | 7 | Wait field [3:0], strobe delay [4], late select [5], hold [6] |
| rsp_done | output | 1 | Completion pulse in the last access cycle |
| rsp_rdata | output | 32 | Last captured read word |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 2 | Per-lane write strobes, active low |
| bus_addr | output | 24 | Address bus |
| bus_dout | output | 32 | Write data to the bus |
| bus_doe | output | 1 | Data bus output enable |
| bus_din | input | 32 | Read data from the bus |

## Verification
A wrong phase or wait count shows up at the ports within one cycle. A strobe rises early or late, or the completion pulse moves, so the bench compares every strobe cycle by cycle against a length computed from the configuration word. A wrong continuation flag shows only in the first cycle of an access joined to the one before it with late select set, where chip select goes high for one cycle. A wrong capture edge or data latch shows on the read-data output one cycle after the read completes, where a scoreboard queue of expected words catches it.

// File: rtl/xbc_pkg.sv
package xbc_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ADDR,
      PH_GAP,
      PH_STRB,
      PH_HOLD
   } xbc_phase_e;
endpackage

// File: rtl/xbc_seq.sv
module xbc_seq
   import xbc_pkg::*;
#(
   parameter int WAIT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [WAIT_W-1:0] cfg_wait,
   input  logic              cfg_dly,
   input  logic              cfg_late,
   input  logic              cfg_hold,
   output xbc_phase_e        phase,
   output logic              accept,
   output logic              final_cyc,
   output logic              cont,
   output logic              late_q
);
   logic [WAIT_W-1:0] wait_q;
   logic [WAIT_W-1:0] cnt;
   logic              dly_q;
   logic              hold_q;

   assign final_cyc = (phase == PH_STRB) && (cnt == '0);
   assign accept    = req_valid &&
                      ((phase == PH_IDLE) || (phase == PH_HOLD) || final_cyc);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         cnt    <= '0;
         wait_q <= '0;
         dly_q  <= 1'b0;
         hold_q <= 1'b0;
         late_q <= 1'b0;
         cont   <= 1'b0;
      end else if (accept) begin
         phase  <= PH_ADDR;
         wait_q <= cfg_wait;
         dly_q  <= cfg_dly;
         hold_q <= cfg_hold;
         late_q <= cfg_late;
         cont   <= (phase != PH_IDLE);
      end else begin
         case (phase)
            PH_ADDR: begin
               phase <= dly_q ? PH_GAP : PH_STRB;
               cnt   <= wait_q;
            end
            PH_GAP:  phase <= PH_STRB;
            PH_STRB: begin
               if (cnt != '0) cnt <= cnt - 1'b1;
               else           phase <= hold_q ? PH_HOLD : PH_IDLE;
            end
            PH_HOLD: phase <= PH_IDLE;
            default: phase <= PH_IDLE;
         endcase
      end
   end

   AST_WAIT_KEEPS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_STRB && cnt != '0) |=> (phase == PH_STRB)); // R7
   AST_ADDR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_ADDR) |=> (phase == PH_GAP || phase == PH_STRB)); // R8
   AST_HOLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_HOLD && !req_valid) |=> (phase == PH_IDLE)); // R6
endmodule

// File: rtl/xbc_strobe.sv
module xbc_strobe
   import xbc_pkg::*;
#(
   parameter int LANES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  xbc_phase_e       phase,
   input  logic             is_write,
   input  logic [LANES-1:0] lanes,
   input  logic             cont,
   input  logic             late,
   output logic             as_n,
   output logic             cs_n,
   output logic             rd_n,
   output logic [LANES-1:0] wr_n
);
   logic strb_on;
   logic cs_on;

   assign strb_on = (phase == PH_STRB);

   always_comb begin
      case (phase)
         PH_ADDR:                   cs_on = !late || cont;
         PH_GAP, PH_STRB, PH_HOLD:  cs_on = 1'b1;
         default:                   cs_on = 1'b0;
      endcase
   end

   assign as_n = (phase != PH_ADDR);
   assign cs_n = !cs_on;
   assign rd_n = !(strb_on && !is_write);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign wr_n[i] = !(strb_on && is_write && lanes[i]);
   end

   AST_AS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      !as_n |=> as_n); // R3
   AST_CS_COVERS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_n || wr_n != '1) |-> !cs_n); // R4
   AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && wr_n != '1)); // R10
endmodule

// File: rtl/xbc_data.sv
module xbc_data
   import xbc_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 32,
   parameter int LANES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              req_write,
   input  logic [LANES-1:0]  req_lanes,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  xbc_phase_e        phase,
   input  logic              final_cyc,
   input  logic [DATA_W-1:0] bus_din,
   output logic              write_q,
   output logic [LANES-1:0]  lanes_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] dout_q,
   output logic              doe,
   output logic [DATA_W-1:0] rdata_q
);
   logic [DATA_W-1:0] wdata_q;
   logic              doe_tail;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         write_q  <= 1'b0;
         lanes_q  <= '0;
         addr_q   <= '0;
         wdata_q  <= '0;
         dout_q   <= '0;
         rdata_q  <= '0;
         doe_tail <= 1'b0;
      end else begin
         if (accept) begin
            write_q <= req_write;
            lanes_q <= req_lanes;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
         end
         if (phase == PH_ADDR && write_q) dout_q <= wdata_q;
         if (final_cyc && !write_q)       rdata_q <= bus_din;
         doe_tail <= final_cyc && write_q;
      end
   end

   assign doe = ((phase == PH_STRB) && write_q) || doe_tail;

   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_GAP || phase == PH_STRB) |-> $stable(addr_q)); // R3
   AST_DOE_TAIL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (doe_tail && !(phase == PH_STRB && write_q)) |=> (!doe || phase == PH_STRB)); // R10
endmodule

// File: rtl/ext_bus_cycle_ctrl.sv
module ext_bus_cycle_ctrl
   import xbc_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 32,
   parameter int LANES  = 2,
   parameter int WAIT_W = 4,
   localparam int CFG_W = WAIT_W + 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [LANES-1:0]  req_lanes,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [CFG_W-1:0]  cfg_word,
   output logic              rsp_done,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              bus_as_n,
   output logic              bus_cs_n,
   output logic              bus_rd_n,
   output logic [LANES-1:0]  bus_wr_n,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bus_doe,
   input  logic [DATA_W-1:0] bus_din
);
   if (DATA_W % LANES != 0) begin : g_bad_lanes
      $error("DATA_W must split evenly over LANES");
   end
   if (WAIT_W < 1 || WAIT_W > 8) begin : g_bad_wait
      $error("WAIT_W must lie in 1..8");
   end

   xbc_phase_e       phase;
   logic             accept;
   logic             final_cyc;
   logic             cont;
   logic             late_q;
   logic             write_q;
   logic [LANES-1:0] lanes_q;

   xbc_seq #(.WAIT_W(WAIT_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .cfg_wait  (cfg_word[WAIT_W-1:0]),
      .cfg_dly   (cfg_word[WAIT_W]),
      .cfg_late  (cfg_word[WAIT_W+1]),
      .cfg_hold  (cfg_word[WAIT_W+2]),
      .phase     (phase),
      .accept    (accept),
      .final_cyc (final_cyc),
      .cont      (cont),
      .late_q    (late_q)
   );

   xbc_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_data (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .req_write (req_write),
      .req_lanes (req_lanes),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .phase     (phase),
      .final_cyc (final_cyc),
      .bus_din   (bus_din),
      .write_q   (write_q),
      .lanes_q   (lanes_q),
      .addr_q    (bus_addr),
      .dout_q    (bus_dout),
      .doe       (bus_doe),
      .rdata_q   (rsp_rdata)
   );

   xbc_strobe #(.LANES(LANES)) u_strobe (
      .clk      (clk),
      .rst_n    (rst_n),
      .phase    (phase),
      .is_write (write_q),
      .lanes    (lanes_q),
      .cont     (cont),
      .late     (late_q),
      .as_n     (bus_as_n),
      .cs_n     (bus_cs_n),
      .rd_n     (bus_rd_n),
      .wr_n     (bus_wr_n)
   );

   assign rsp_done  = final_cyc;
   assign req_ready = (phase == PH_IDLE) || (phase == PH_HOLD) || final_cyc;

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && !req_valid) |=> !rsp_done); // R11
   AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !bus_as_n); // R11
   AST_WR_NEEDS_DOE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_n != '1) |-> bus_doe); // R10
endmodule

// File: tb/ext_bus_cycle_ctrl_tb.sv
module ext_bus_cycle_ctrl_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [1:0]  req_lanes = '0;
   logic [23:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [6:0]  cfg_word = '0;
   logic        rsp_done;
   logic [31:0] rsp_rdata;
   logic        bus_as_n, bus_cs_n, bus_rd_n, bus_doe;
   logic [1:0]  bus_wr_n;
   logic [23:0] bus_addr;
   logic [31:0] bus_dout;
   logic [31:0] bus_din;

   int          n_chk = 0;
   int          n_bad = 0;
   bit          finished = 0;
   logic [31:0] exp_q[$];
   bit          rd_pend = 0;
   logic [31:0] mon_e;

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [31:0] mem_word(input logic [23:0] a);
      return {a[7:0] ^ 8'h3C, a};
   endfunction

   assign bus_din = mem_word(bus_addr);

   ext_bus_cycle_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_lanes(req_lanes), .req_addr(req_addr),
      .req_wdata(req_wdata), .cfg_word(cfg_word), .rsp_done(rsp_done),
      .rsp_rdata(rsp_rdata), .bus_as_n(bus_as_n), .bus_cs_n(bus_cs_n),
      .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_addr(bus_addr),
      .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Scoreboard monitor: one cycle after a read completes, compare the captured word (R9)
   always @(negedge clk) begin
      if (rd_pend) begin
         if (exp_q.size() == 0) chk(1'b0, "R9", rsp_rdata, 32'h0);
         else begin
            mon_e = exp_q.pop_front();
            chk(rsp_rdata == mon_e, "R9", rsp_rdata, mon_e);
         end
      end
      rd_pend = rst_n && rsp_done && !bus_rd_n;
   end

   // Issue one access at a negedge where ready is expected; return at the negedge of its last cycle
   task automatic access(input bit w, input logic [1:0] ln, input logic [23:0] a,
                         input logic [31:0] d, input logic [6:0] c, input bit cont);
      int dly = int'(c[4]);
      int wt  = int'(c[3:0]);
      int ln_total = 2 + dly + wt;
      int s = 2 + dly;
      string stag;
      stag = c[4] ? "R8" : ((c == 7'h00) ? "R2" : "R7");
      chk(req_ready == 1'b1, "R11", req_ready, 1);
      req_valid = 1'b1; req_write = w; req_lanes = ln;
      req_addr = a; req_wdata = d; cfg_word = c;
      for (int k = 1; k <= ln_total; k++) begin
         logic strb;
         logic cs_on;
         @(negedge clk);
         if (k == 1) begin
            req_valid = 1'b0; cfg_word = 7'h7F ^ c;
            req_addr = ~a; req_wdata = ~d; req_write = ~w; req_lanes = ~ln;
         end
         strb  = (k >= s);
         cs_on = (k == 1) ? (!c[5] || cont) : 1'b1;
         chk(bus_as_n == (k != 1), "R3", bus_as_n, k != 1);
         chk(bus_addr == a, "R3", bus_addr, a);
         chk(bus_cs_n == !cs_on, cont ? "R5" : "R4", bus_cs_n, !cs_on);
         chk(bus_rd_n == !(strb && !w), stag, bus_rd_n, !(strb && !w));
         chk(bus_wr_n == ((strb && w) ? ~ln : 2'b11), "R10", bus_wr_n,
             (strb && w) ? ~ln : 2'b11);
         if (strb && w) begin
            chk(bus_doe == 1'b1, "R10", bus_doe, 1);
            chk(bus_dout == d, "R10", bus_dout, d);
         end
         chk(rsp_done == (k == ln_total), (c == 7'h00) ? "R2" : "R11", rsp_done, k == ln_total);
         chk(req_ready == (k == ln_total), "R11", req_ready, k == ln_total);
         if (k == ln_total) chk(rsp_done == 1'b1, "R12", rsp_done, 1);
      end
      if (!w) exp_q.push_back(mem_word(a));
   endtask

   // Two cycles after an access with no follow-on request
   task automatic tail(input bit w, input logic [6:0] c);
      @(negedge clk);
      chk(bus_cs_n == !c[6], "R6", bus_cs_n, !c[6]);
      chk(bus_doe == w, "R10", bus_doe, w);
      chk(bus_as_n == 1'b1 && bus_rd_n == 1'b1 && bus_wr_n == 2'b11, "R10",
          {bus_as_n, bus_rd_n, bus_wr_n}, 4'hF);
      chk(req_ready == 1'b1, "R11", req_ready, 1);
      @(negedge clk);
      chk(bus_cs_n == 1'b1, "R6", bus_cs_n, 1);
      chk(bus_doe == 1'b0, "R10", bus_doe, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(bus_as_n && bus_cs_n && bus_rd_n && bus_wr_n == 2'b11, "R1",
          {bus_as_n, bus_cs_n, bus_rd_n, bus_wr_n}, 5'h1F);
      chk(bus_doe == 1'b0 && rsp_done == 1'b0, "R1", {bus_doe, rsp_done}, 0);
      chk(req_ready == 1'b1, "R1", req_ready, 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(bus_cs_n == 1'b1 && req_ready == 1'b1, "R1", {bus_cs_n, req_ready}, 2'b11);

      access(1'b0, 2'b00, 24'h000104, 32'h0, 7'h00, 1'b0);  tail(1'b0, 7'h00);
      access(1'b1, 2'b11, 24'h000208, 32'hCAFE_F00D, 7'h00, 1'b0);  tail(1'b1, 7'h00);
      access(1'b0, 2'b00, 24'h12_3450, 32'h0, 7'h03, 1'b0);  tail(1'b0, 7'h03);
      access(1'b0, 2'b00, 24'hAB_0010, 32'h0, 7'h11, 1'b0);  tail(1'b0, 7'h11);
      access(1'b0, 2'b00, 24'h00_7F00, 32'h0, 7'h20, 1'b0);  tail(1'b0, 7'h20);
      access(1'b1, 2'b10, 24'h55_0002, 32'h1234_5678, 7'h42, 1'b0);  tail(1'b1, 7'h42);

      // Back-to-back joins from the completion cycle
      access(1'b0, 2'b00, 24'h00_0A00, 32'h0, 7'h00, 1'b0);
      access(1'b1, 2'b01, 24'h00_0A04, 32'h8765_4321, 7'h21, 1'b1);
      access(1'b0, 2'b00, 24'h00_0A08, 32'h0, 7'h22, 1'b1);
      tail(1'b0, 7'h22);

      // Join from a hold cycle with late select set
      access(1'b0, 2'b00, 24'h77_0100, 32'h0, 7'h60, 1'b0);
      @(negedge clk);
      chk(bus_cs_n == 1'b0, "R6", bus_cs_n, 0);
      access(1'b1, 2'b11, 24'h77_0104, 32'hDEAD_BEEF, 7'h34, 1'b1);
      tail(1'b1, 7'h34);

      access(1'b0, 2'b00, 24'hFF_FFFC, 32'h0, 7'h0F, 1'b0);  tail(1'b0, 7'h0F);
      repeat (2) @(negedge clk);
      chk(exp_q.size() == 0, "R9", exp_q.size(), 0);

      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!finished) begin
         finished = 1;
         n_chk++; n_bad++;
         $display("FAIL R11: watchdog expired, actual %h expected %h", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule